// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block converts a 48-bit virtual address into a 56-bit physical address by walking a four-level radix page table held in memory. Each level consumes 9 bits of the virtual page number. A request carries the physical base of the top-level table, the kind of access (load, store or fetch), the requesting privilege, a flag that lets execute-only pages satisfy loads, and a flag that lets supervisor code touch user pages. The walker fetches one 8-byte table entry per level over a single-outstanding request/response memory port. It follows pointer entries downward and stops at the first leaf or at the first fault.

On success it reports the physical address, the leaf entry, the address that entry was read from, the level at which the leaf was found, and whether any entry on the path was marked global. Leaves that still need their accessed or dirty flag set are either written back to memory in place or refused, depending on a per-request enable. A single-cycle done pulse with a 3-bit fault code closes every walk. Fault codes: 0 none, 1 access error, 2 invalid entry, 3 misaligned large page, 4 permission, 5 flag update refused.

Top module: `ptw48_walker`

## Requirements
- R1: `req_ready_o` is high only while idle, and a request is taken on a cycle with `req_valid_i` and `req_ready_o` both high. Every accepted request produces exactly one single-cycle `done_o` pulse, after which `req_ready_o` is high again. `mem_req_o` is never high on two consecutive cycles.
- R2: The walk starts at level 3. At each level the entry is read from the current table base plus 8 times the level's index, where the indices are VA[47:39], VA[38:30], VA[29:21] and VA[20:12] for levels 3 to 0. A pointer entry found above level 0 makes its PPN shifted left by 12 the next table base.
- R3: A read answered with `mem_err_i` ends the walk with fault 1, and no further memory request is made.
- R4: An entry is laid out as V bit 0, R bit 1, W bit 2, X bit 3, U bit 4, G bit 5, A bit 6, D bit 7 and PPN in bits 53:10. An entry with V clear, or with W set and R clear, ends the walk with fault 2 at any level.
- R5: An entry with R, W and X all clear is a pointer. A pointer found at level 0 ends the walk with fault 2.
- R6: Access codes are 0 load, 1 store and 2 fetch (3 always fails). A load needs R, or X while the load-from-executable flag is set. A store needs W and a fetch needs X. A user request needs U. A supervisor request to a page with U set succeeds only for load or store and only with the user-access flag set. A failed check gives fault 4.
- R7: A leaf at level L above 0 whose PPN has any of its low 9·L bits set gives fault 3. The permission check of R6 takes priority over this one.
- R8: On success `paddr_o` is the leaf PPN ORed with the low 9·L bits of VA[47:12], followed by VA[11:0].
- R9: `global_o` is the OR of the G bits of every entry read on a successful walk.
- R10: A leaf with A clear, or a store to a leaf with D clear, needs an update. With `req_hw_upd_i` low it gives fault 5 and makes no memory write.
- R11: With `req_hw_upd_i` high, a needed update writes the entry with A set (and D set on a store) back to the address it was read from, and `pte_o` reports the updated entry. A write answered with `mem_err_i` gives fault 1.
- R12: On success `level_o` is the level of the leaf and `pte_addr_o` is the address the leaf was read from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 48 | Virtual address |
| req_root_i | input | 56 | Physical base of the level-3 table |
| req_acc_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user_i | input | 1 | 1 user request, 0 supervisor request |
| req_xread_i | input | 1 | Loads may use execute-only pages |
| req_usr_ok_i | input | 1 | Supervisor may load/store user pages |
| req_hw_upd_i | input | 1 | Hardware may write back A/D flags |
| mem_req_o | output | 1 | Memory request, one cycle |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 56 | Entry address |
| mem_wdata_o | output | 64 | Entry value for a write |
| mem_rsp_valid_i | input | 1 | Memory response valid |
| mem_rdata_i | input | 64 | Entry value read |
| mem_err_i | input | 1 | Memory response carries an error |
| done_o | output | 1 | Walk finished, one cycle |
| fault_o | output | 3 | Fault code, 0 when successful |
| paddr_o | output | 56 | Translated physical address |
| pte_o | output | 64 | Leaf entry, after any update |
| pte_addr_o | output | 56 | Address of the leaf entry |
| level_o | output | 2 | Level of the leaf |
| global_o | output | 1 | Some entry on the path had G set |

## Verification
The bench builds the walker with its default geometry (48-bit virtual, 56-bit physical, four levels of 9 bits) against a behavioural memory of eight 4 KiB pages, which is enough to hold one table per level plus an unmapped region that returns errors. With that layout a level-0 leaf can be swept over all 256 values of its flag byte, crossed with every access kind and every combination of privilege and the two access flags, so the full permission and update decision table is reached. Large pages at levels 1 to 3, pointers with every G pattern, two different index paths, and read and write errors cover the remaining ordering and composition cases.

// File: rtl/ptw48_pkg.sv
package ptw48_pkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ACCESS = 3'd1,
    FLT_BADPTE = 3'd2,
    FLT_ALIGN  = 3'd3,
    FLT_PERM   = 3'd4,
    FLT_UPDATE = 3'd5
  } fault_e;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  // low byte of an entry
  typedef struct packed {
    logic d;
    logic a;
    logic g;
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } pte_flags_t;

  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned BIT_A   = 6;
  localparam int unsigned BIT_D   = 7;

endpackage

// File: rtl/ptw48_perm.sv
module ptw48_perm
  import ptw48_pkg::*;
(
  input  logic       r_i,
  input  logic       w_i,
  input  logic       x_i,
  input  logic       u_i,
  input  logic [1:0] acc_i,
  input  logic       user_i,
  input  logic       xread_i,
  input  logic       usr_ok_i,
  output logic       ok_o
);

  logic kind_ok;
  logic priv_ok;

  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  kind_ok = r_i | (x_i & xread_i);
      ACC_STORE: kind_ok = w_i;
      ACC_FETCH: kind_ok = x_i;
      default:   kind_ok = 1'b0;
    endcase
    if (user_i) priv_ok = u_i;
    else        priv_ok = !u_i || (usr_ok_i && acc_i != ACC_FETCH);
    ok_o = kind_ok & priv_ok;
  end

endmodule

// File: rtl/ptw48_leaf.sv
module ptw48_leaf #(
  parameter int unsigned PPN_W = 44,
  parameter int unsigned VPN_W = 36,
  parameter int unsigned IDX_W = 9,
  parameter int unsigned LVL_W = 2
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic             a_i,
  input  logic             d_i,
  input  logic             store_i,
  output logic             misaligned_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic             set_a_o,
  output logic             set_d_o
);

  logic [PPN_W-1:0] vpn_ext;
  logic [PPN_W-1:0] low_mask;

  generate
    if (PPN_W > VPN_W) begin : g_ext
      assign vpn_ext = {{(PPN_W-VPN_W){1'b0}}, vpn_i};
    end else if (PPN_W == VPN_W) begin : g_same
      assign vpn_ext = vpn_i;
    end else begin : g_trunc
      assign vpn_ext = vpn_i[PPN_W-1:0];
    end
  endgenerate

  // bits below the large-page boundary for this level
  assign low_mask     = ~({PPN_W{1'b1}} << (level_i * IDX_W));
  assign misaligned_o = |(ppn_i & low_mask);
  assign ppn_o        = ppn_i | (vpn_ext & low_mask);

  assign set_a_o = !a_i;
  assign set_d_o = store_i && !d_i;

endmodule

// File: rtl/ptw48_walker.sv
module ptw48_walker
  import ptw48_pkg::*;
#(
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 56,
  parameter int unsigned PTE_W   = 64,
  parameter int unsigned LEVELS  = 4,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned OFS_W   = 12,
  parameter int unsigned PPN_LSB = 10,
  parameter int unsigned LVL_W   = $clog2(LEVELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [PA_W-1:0]  req_root_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic             req_xread_i,
  input  logic             req_usr_ok_i,
  input  logic             req_hw_upd_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [PTE_W-1:0] mem_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  input  logic             mem_err_i,
  output logic             done_o,
  output logic [2:0]       fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [PTE_W-1:0] pte_o,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [LVL_W-1:0] level_o,
  output logic             global_o
);

  localparam int unsigned PPN_W   = PA_W - OFS_W;
  localparam int unsigned VPN_W   = VA_W - OFS_W;
  localparam int unsigned ENT_LOG = $clog2(PTE_W / 8);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RD_W, S_WB, S_WB_W, S_DONE} state_e;

  state_e           state_q;
  logic [LVL_W-1:0] level_q;
  logic [PA_W-1:0]  base_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic             user_q, xread_q, usr_ok_q, upd_en_q;
  logic             glob_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  pte_addr_q;
  logic [PA_W-1:0]  paddr_q;
  fault_e           fault_q;

  // index slices per level
  logic [IDX_W-1:0] vpn_slc [LEVELS];
  generate
    for (genvar l = 0; l < LEVELS; l++) begin : g_slc
      assign vpn_slc[l] = va_q[OFS_W + l*IDX_W +: IDX_W];
    end
  endgenerate

  logic [PA_W-1:0] cur_addr;
  assign cur_addr = base_q + PA_W'({vpn_slc[level_q], {ENT_LOG{1'b0}}});

  // decode of the returned entry
  pte_flags_t       leaf_flags;
  logic [PPN_W-1:0] ppn_in;
  logic             bad_ent, is_ptr;
  assign leaf_flags = pte_flags_t'(mem_rdata_i[FLAG_W-1:0]);
  assign ppn_in     = mem_rdata_i[PPN_LSB +: PPN_W];
  assign bad_ent    = !leaf_flags.v || (leaf_flags.w && !leaf_flags.r);
  assign is_ptr     = !leaf_flags.r && !leaf_flags.w && !leaf_flags.x;

  logic perm_ok;
  ptw48_perm u_perm (
    .r_i      (leaf_flags.r),
    .w_i      (leaf_flags.w),
    .x_i      (leaf_flags.x),
    .u_i      (leaf_flags.u),
    .acc_i    (acc_q),
    .user_i   (user_q),
    .xread_i  (xread_q),
    .usr_ok_i (usr_ok_q),
    .ok_o     (perm_ok)
  );

  logic             misaligned, set_a, set_d;
  logic [PPN_W-1:0] ppn_out;
  ptw48_leaf #(
    .PPN_W (PPN_W),
    .VPN_W (VPN_W),
    .IDX_W (IDX_W),
    .LVL_W (LVL_W)
  ) u_leaf (
    .level_i      (level_q),
    .ppn_i        (ppn_in),
    .vpn_i        (va_q[VA_W-1:OFS_W]),
    .a_i          (leaf_flags.a),
    .d_i          (leaf_flags.d),
    .store_i      (acc_q == ACC_STORE),
    .misaligned_o (misaligned),
    .ppn_o        (ppn_out),
    .set_a_o      (set_a),
    .set_d_o      (set_d)
  );

  logic [PTE_W-1:0] pte_upd;
  assign pte_upd = mem_rdata_i | (PTE_W'(set_a) << BIT_A) | (PTE_W'(set_d) << BIT_D);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      level_q    <= '0;
      base_q     <= '0;
      va_q       <= '0;
      acc_q      <= '0;
      user_q     <= 1'b0;
      xread_q    <= 1'b0;
      usr_ok_q   <= 1'b0;
      upd_en_q   <= 1'b0;
      glob_q     <= 1'b0;
      pte_q      <= '0;
      pte_addr_q <= '0;
      paddr_q    <= '0;
      fault_q    <= FLT_NONE;
    end else begin
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q     <= req_va_i;
          base_q   <= req_root_i;
          acc_q    <= req_acc_i;
          user_q   <= req_user_i;
          xread_q  <= req_xread_i;
          usr_ok_q <= req_usr_ok_i;
          upd_en_q <= req_hw_upd_i;
          level_q  <= LVL_W'(LEVELS - 1);
          glob_q   <= 1'b0;
          fault_q  <= FLT_NONE;
          state_q  <= S_RD;
        end
        S_RD: begin
          pte_addr_q <= cur_addr;
          state_q    <= S_RD_W;
        end
        S_RD_W: if (mem_rsp_valid_i) begin
          if (mem_err_i) begin
            fault_q <= FLT_ACCESS;
            state_q <= S_DONE;
          end else if (bad_ent) begin
            fault_q <= FLT_BADPTE;
            state_q <= S_DONE;
          end else if (is_ptr) begin
            if (level_q != '0) begin
              base_q  <= {ppn_in, {OFS_W{1'b0}}};
              level_q <= level_q - LVL_W'(1);
              glob_q  <= glob_q | leaf_flags.g;
              state_q <= S_RD;
            end else begin
              fault_q <= FLT_BADPTE;
              state_q <= S_DONE;
            end
          end else begin
            glob_q <= glob_q | leaf_flags.g;
            pte_q  <= mem_rdata_i;
            if (!perm_ok) begin
              fault_q <= FLT_PERM;
              state_q <= S_DONE;
            end else if (misaligned) begin
              fault_q <= FLT_ALIGN;
              state_q <= S_DONE;
            end else begin
              paddr_q <= {ppn_out, va_q[OFS_W-1:0]};
              if (set_a || set_d) begin
                if (upd_en_q) begin
                  pte_q   <= pte_upd;
                  state_q <= S_WB;
                end else begin
                  fault_q <= FLT_UPDATE;
                  state_q <= S_DONE;
                end
              end else begin
                state_q <= S_DONE;
              end
            end
          end
        end
        S_WB: state_q <= S_WB_W;
        S_WB_W: if (mem_rsp_valid_i) begin
          if (mem_err_i) fault_q <= FLT_ACCESS;
          state_q <= S_DONE;
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign mem_req_o   = (state_q == S_RD) || (state_q == S_WB);
  assign mem_we_o    = (state_q == S_WB);
  assign mem_addr_o  = (state_q == S_WB) ? pte_addr_q : cur_addr;
  assign mem_wdata_o = pte_q;
  assign done_o      = (state_q == S_DONE);
  assign fault_o     = fault_q;
  assign paddr_o     = paddr_q;
  assign pte_o       = pte_q;
  assign pte_addr_o  = pte_addr_q;
  assign level_o     = level_q;
  assign global_o    = glob_q;

  AST_MEM_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R1
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R1
  AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD && $past(state_q) == S_RD_W) |-> level_q == $past(level_q) - LVL_W'(1)); // R2
  AST_SUP_NO_USER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RD_W && mem_rsp_valid_i && !user_q && leaf_flags.u && acc_q == ACC_FETCH)
      |-> !perm_ok); // R6
  AST_ALIGN_ONLY_LARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_ALIGN) |-> level_o != '0); // R7
  AST_OFFSET_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_NONE) |-> paddr_o[OFS_W-1:0] == va_q[OFS_W-1:0]); // R8
  AST_UPDATE_ONLY_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_UPDATE) |-> !upd_en_q); // R10
  AST_WB_SETS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[BIT_A]); // R11

endmodule

// File: tb/ptw48_walker_test.sv
module ptw48_walker_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic [55:0] req_root = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0, req_xread = 1'b0, req_usr_ok = 1'b0, req_hw_upd = 1'b0;
  logic        mem_req, mem_we;
  logic [55:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        rsp_valid = 1'b0;
  logic [63:0] rsp_data = '0;
  logic        rsp_err = 1'b0;
  logic        done;
  logic [2:0]  fault;
  logic [55:0] paddr, pte_addr;
  logic [63:0] pte;
  logic [1:0]  level;
  logic        glob;

  ptw48_walker uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_root_i(req_root), .req_acc_i(req_acc),
    .req_user_i(req_user), .req_xread_i(req_xread), .req_usr_ok_i(req_usr_ok),
    .req_hw_upd_i(req_hw_upd),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rsp_valid_i(rsp_valid), .mem_rdata_i(rsp_data), .mem_err_i(rsp_err),
    .done_o(done), .fault_o(fault), .paddr_o(paddr), .pte_o(pte),
    .pte_addr_o(pte_addr), .level_o(level), .global_o(glob)
  );

  // behavioural memory: 8 pages, addresses from 0x8000 up return errors
  localparam logic [55:0] MEM_TOP = 56'h8000;
  localparam logic [55:0] TBL [4] = '{56'h4000, 56'h3000, 56'h2000, 56'h1000}; // by level
  logic [63:0] mem [0:4095];
  logic        pend = 1'b0, perr = 1'b0, wr_err_en = 1'b0;
  logic [63:0] pdata = '0;
  int          rd_n, wr_n;
  logic [55:0] rd_log [0:7];

  always @(negedge clk) begin
    rsp_valid = pend;
    rsp_data  = pdata;
    rsp_err   = perr;
    pend      = 1'b0;
    if (mem_req) begin
      pend = 1'b1;
      perr = (mem_addr >= MEM_TOP) || (mem_we && wr_err_en);
      if (mem_we) begin
        wr_n++;
        if (!perr) mem[mem_addr[14:3]] = mem_wdata;
      end else begin
        if (rd_n < 8) rd_log[rd_n] = mem_addr;
        rd_n++;
        pdata = perr ? 64'h0 : mem[mem_addr[14:3]];
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] fl);
    return {10'b0, ppn, 2'b00, fl};
  endfunction

  function automatic logic [8:0] idx_of(input logic [47:0] va, input int l);
    return va[12 + 9*l +: 9];
  endfunction

  function automatic int ent(input int l, input logic [47:0] va);
    return int'(TBL[l][14:3]) + int'(idx_of(va, l));
  endfunction

  // pointer chain for va, G bits per level 3..1 in g[2:0]
  task automatic set_ptrs(input logic [47:0] va, input logic [2:0] g);
    for (int l = 3; l >= 1; l--)
      mem[ent(l, va)] = mk_pte(44'(TBL[l-1] >> 12), {2'b00, g[l-1], 5'b00001});
  endtask

  logic [2:0]  c_fault;
  logic [55:0] c_paddr, c_pte_addr;
  logic [63:0] c_pte;
  logic [1:0]  c_level;
  logic        c_glob, c_early_ready, c_post_done, c_post_ready, c_got;

  task automatic walk(input logic [47:0] va, input logic [55:0] root, input logic [1:0] acc,
                      input logic user, input logic xr, input logic uok, input logic upd);
    @(negedge clk);
    rd_n = 0; wr_n = 0;
    req_va = va; req_root = root; req_acc = acc;
    req_user = user; req_xread = xr; req_usr_ok = uok; req_hw_upd = upd;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    c_got = 1'b0; c_early_ready = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (done) begin
        c_got = 1'b1; c_fault = fault; c_paddr = paddr; c_pte = pte;
        c_pte_addr = pte_addr; c_level = level; c_glob = glob;
        break;
      end
      if (req_ready) c_early_ready = 1'b1;
      @(negedge clk);
    end
    if (!c_got) check("R1 walk timeout", 64'(c_got), 64'd1);
    @(negedge clk);
    c_post_done = done; c_post_ready = req_ready;
  endtask

  function automatic logic exp_perm(input logic [7:0] f, input logic [1:0] acc,
                                    input logic user, input logic xr, input logic uok);
    logic k, p;
    case (acc)
      2'd0:    k = f[1] | (f[3] & xr);
      2'd1:    k = f[2];
      2'd2:    k = f[3];
      default: k = 1'b0;
    endcase
    p = user ? f[4] : (!f[4] || (uok && acc != 2'd2));
    return k & p;
  endfunction

  localparam logic [47:0] VA_A = {9'h005, 9'h1A3, 9'h0F0, 9'h111, 12'hABC};
  localparam logic [47:0] VA_B = {9'h1FF, 9'h000, 9'h12D, 9'h0A7, 12'h004};
  localparam logic [43:0] LPPN = 44'h00ABCDE12;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R1 reset done", 64'(done), 64'd0);
    check("R1 reset mem_req", 64'(mem_req), 64'd0);

    // R2 address sequence on two index paths, plus handshake R1
    set_ptrs(VA_A, 3'b000);
    mem[ent(0, VA_A)] = mk_pte(LPPN, 8'hCF);
    walk(VA_A, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 read count", 64'(rd_n), 64'd4);
    for (int l = 3; l >= 0; l--)
      check("R2 entry address", 64'(rd_log[3-l]), 64'(TBL[l] + 56'(idx_of(VA_A, l)) * 8));
    check("R1 busy during walk", 64'(c_early_ready), 64'd0);
    check("R1 single done", 64'(c_post_done), 64'd0);
    check("R1 ready after done", 64'(c_post_ready), 64'd1);
    check("R12 level", 64'(c_level), 64'd0);
    check("R12 pte address", 64'(c_pte_addr), 64'(TBL[0] + 56'(idx_of(VA_A, 0)) * 8));
    set_ptrs(VA_B, 3'b000);
    mem[ent(0, VA_B)] = mk_pte(LPPN, 8'hCF);
    walk(VA_B, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int l = 3; l >= 0; l--)
      check("R2 entry address B", 64'(rd_log[3-l]), 64'(TBL[l] + 56'(idx_of(VA_B, l)) * 8));
    check("R8 paddr B", 64'(c_paddr), 64'({LPPN, VA_B[11:0]}));

    // R9 global over all pointer G patterns
    for (int g = 0; g < 8; g++) begin
      set_ptrs(VA_A, 3'(g));
      mem[ent(0, VA_A)] = mk_pte(LPPN, 8'hCF);
      walk(VA_A, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R9 global", 64'(c_glob), 64'(g != 0));
    end
    set_ptrs(VA_A, 3'b000);

    // R3 read error at the root
    walk(VA_A, 56'h9000, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R3 fault", 64'(c_fault), 64'd1);
    check("R3 no further reads", 64'(rd_n), 64'd1);

    // R4 invalid entry at level 3
    mem[ent(3, VA_A)] = mk_pte(44'h2, 8'h00);
    walk(VA_A, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 invalid upper", 64'(c_fault), 64'd2);
    check("R4 stops walk", 64'(rd_n), 64'd1);
    mem[ent(3, VA_A)] = mk_pte(44'h2, 8'h05); // W without R
    walk(VA_A, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R4 W without R", 64'(c_fault), 64'd2);
    set_ptrs(VA_A, 3'b000);

    // R5 pointer at level 0
    mem[ent(0, VA_A)] = mk_pte(44'h5, 8'h01);
    walk(VA_A, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 pointer at level 0", 64'(c_fault), 64'd2);

    // R11 write error on update
    mem[ent(0, VA_A)] = mk_pte(LPPN, 8'h0F);
    wr_err_en = 1'b1;
    walk(VA_A, TBL[3], 2'd1, 1'b0, 1'b0, 1'b0, 1'b1);
    wr_err_en = 1'b0;
    check("R11 write error fault", 64'(c_fault), 64'd1);
    check("R11 write attempted", 64'(wr_n), 64'd1);

    // R7/R8/R12 large pages
    for (int l = 1; l <= 3; l++) begin
      logic [43:0] msk, ppn_ok;
      msk    = (44'd1 << (9*l)) - 44'd1;
      ppn_ok = 44'h123 << (9*l);
      set_ptrs(VA_A, 3'b000);
      mem[ent(l, VA_A)] = mk_pte(ppn_ok, 8'hCF);
      walk(VA_A, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R8 large page fault", 64'(c_fault), 64'd0);
      check("R8 large page paddr", 64'(c_paddr),
            64'({ppn_ok | ({8'b0, VA_A[47:12]} & msk), VA_A[11:0]}));
      check("R12 large page level", 64'(c_level), 64'(l));
      check("R12 large page address", 64'(c_pte_addr),
            64'(TBL[l] + 56'(idx_of(VA_A, l)) * 8));
      mem[ent(l, VA_A)] = mk_pte(ppn_ok | (44'd1 << (9*l - 1)), 8'hCF);
      walk(VA_A, TBL[3], 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R7 misaligned", 64'(c_fault), 64'd3);
      mem[ent(l, VA_A)] = mk_pte(ppn_ok | 44'd1, 8'hC3); // read-only, store
      walk(VA_A, TBL[3], 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
      check("R7 permission before alignment", 64'(c_fault), 64'd4);
    end
    set_ptrs(VA_A, 3'b000);

    // R6/R10/R11 sweep of every leaf flag byte at level 0
    for (int f = 0; f < 256; f++) begin
      for (int acc = 0; acc < 3; acc++) begin
        for (int ctl = 0; ctl < 8; ctl++) begin
          logic [7:0]  fl;
          logic [63:0] orig, exp_pte;
          logic        upd, need;
          logic [2:0]  ef;
          fl   = 8'(f);
          upd  = fl[5] ^ ctl[0];
          orig = mk_pte(LPPN, fl);
          mem[ent(0, VA_A)] = orig;
          walk(VA_A, TBL[3], 2'(acc), ctl[0], ctl[1], ctl[2], upd);
          need = !fl[6] || (acc == 1 && !fl[7]);
          if (!fl[0] || (fl[2] && !fl[1]))        ef = 3'd2;
          else if (!fl[1] && !fl[2] && !fl[3])    ef = 3'd2;
          else if (!exp_perm(fl, 2'(acc), ctl[0], ctl[1], ctl[2])) ef = 3'd4;
          else if (need && !upd)                  ef = 3'd5;
          else                                    ef = 3'd0;
          check("R6 R10 sweep fault", 64'(c_fault), 64'(ef));
          if (ef == 3'd0) begin
            exp_pte = orig | 64'h40 | ((acc == 1) ? 64'h80 : 64'h0);
            check("R8 sweep paddr", 64'(c_paddr), 64'({LPPN, VA_A[11:0]}));
            check("R11 reported entry", c_pte, exp_pte);
            check("R11 memory entry", mem[ent(0, VA_A)], exp_pte);
            check("R11 write count", 64'(wr_n), 64'(need));
            check("R9 leaf global", 64'(c_glob), 64'(fl[5]));
          end else if (ef == 3'd5) begin
            check("R10 no write", 64'(wr_n), 64'd0);
            check("R10 memory unchanged", mem[ent(0, VA_A)], orig);
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule